// File: doc/BRIEF.md
# Level-Gated Prescaled Timer

This block is an up-counting timer with a clock prescaler and a programmable wrap value. It runs in one of two modes. In free-running mode it advances whenever its enable bit is set. In gated mode it advances only while a selected external input sits at its active level. Software programs the block through a simple write port. The live counter value and a sticky gate-event flag appear directly on outputs.

In gated mode the external input first passes through a synchronizer. A polarity bit then picks whether a high or a low level opens the gate. The counter stops and keeps its value while the gate is closed, and it carries on from that value when the gate opens again. A gate-event flag records each opening and each closing of the gate. Software clears the flag by writing a zero to it.

Top module: `gatedTimer`

## Requirements
- R1: After reset the counter output is 0, the gate-event flag is 0, the block is disabled and in free-running mode, and the prescaler and period registers are 0.
- R2: Register map, written with `wrEn` high and selected by `wrAddr`:
  - Address 0 is control: bit 0 is enable and bit 1 is polarity.
  - Address 1 is mode: bits 2:0 are the mode field and bits 6:4 are the gate-source field.
  - Address 2 is the 16-bit prescaler.
  - Address 3 is the 32-bit period.
  - Address 4 loads the counter.
  - Address 5 is status, with bit 0 as the gate-event flag.
- R3: In free-running mode (mode field not 3'b101) with enable set, the counter advances by one every (prescaler + 1) clocks.
- R4: On the tick after the counter equals the period value, the counter goes to 0.
- R5: While enable is 0, the counter does not change in any mode.
- R6: With the mode field at 3'b101 and the gate-source field at 3'b101, the counter advances only while the synchronized `gateIn` is at its active level. Polarity 0 means active high and polarity 1 means active low. The first increment after a gate change lands on the third rising edge after the input changes.
- R7: In gated mode, a gate-source value other than 3'b101 keeps the gate closed, so the counter does not advance.
- R8: While the gate is closed the counter holds its value, and it resumes from that value when the gate reopens.
- R9: The gate-event flag is set on both the opening and the closing of the gate. It is set one clock after the synchronized input changes, and only when enable is 1, gated mode is selected and the gate source is 3'b101. Otherwise the flag stays unchanged.
- R10: The gate-event flag is sticky. Writing 0 to status bit 0 clears it, and a set in the same cycle takes priority over the clear.
- R11: A write to the counter address loads the written value in place of any increment in that cycle. It also restarts the prescaler phase, so the next increment comes (prescaler + 1) enabled clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 32 | Register write data |
| gateIn | input | 1 | External gate level, asynchronous |
| cntValue | output | 32 | Live counter value |
| trigFlag | output | 1 | Sticky gate-event flag |

## Verification
The assertions assume that `wrEn`, `wrAddr` and `wrData` are synchronous to `clk` and stable around each rising edge. They also assume that `gateIn` holds each level for at least two clocks, so that the synchronizer reports every change. The bench drives all inputs on falling edges and holds each gate level for several cycles. It does not reprogram the period below the live counter value while the counter is running.

// File: rtl/gtPkg.sv
package gtPkg;
  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_MODE   = 3'd1;
  localparam logic [2:0] ADDR_PSC    = 3'd2;
  localparam logic [2:0] ADDR_PER    = 3'd3;
  localparam logic [2:0] ADDR_CNT    = 3'd4;
  localparam logic [2:0] ADDR_STATUS = 3'd5;

  localparam logic [2:0] MODE_GATED  = 3'b101;
  localparam logic [2:0] SRC_CH1     = 3'b101;

  typedef struct packed {
    logic run;
    logic cntLoad;
  } gtStrobe_t;
endpackage

// File: rtl/gtControl.sv
module gtControl
  import gtPkg::*;
#(
  parameter int PRE_W       = 16,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             gateIn,
  output gtStrobe_t        strb,
  output logic [PRE_W-1:0] pscVal,
  output logic [CNT_W-1:0] perVal,
  output logic             trigFlag
);
  localparam int SYNC_N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic             enReg, polReg;
  logic [2:0]       modeReg, srcReg;
  logic [SYNC_N-1:0] syncQ;
  logic             gateSync, gateSyncD;
  logic             gatedMode, srcOk, gateActive, gateEdge, flagClr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      polReg  <= 1'b0;
      modeReg <= '0;
      srcReg  <= '0;
      pscVal  <= '0;
      perVal  <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL: begin
          enReg  <= wrData[0];
          polReg <= wrData[1];
        end
        ADDR_MODE: begin
          modeReg <= wrData[2:0];
          srcReg  <= wrData[6:4];
        end
        ADDR_PSC: pscVal <= wrData[PRE_W-1:0];
        ADDR_PER: perVal <= wrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ     <= '0;
      gateSyncD <= 1'b0;
    end else begin
      syncQ     <= {syncQ[SYNC_N-2:0], gateIn};
      gateSyncD <= gateSync;
    end
  end

  assign gateSync   = syncQ[SYNC_N-1];
  assign gatedMode  = (modeReg == MODE_GATED);
  assign srcOk      = (srcReg == SRC_CH1);
  assign gateActive = srcOk && (gateSync ^ polReg);
  assign gateEdge   = (gateSync != gateSyncD) && enReg && gatedMode && srcOk;
  assign flagClr    = wrEn && (wrAddr == ADDR_STATUS) && !wrData[0];

  always_comb begin
    strb.run     = enReg && (!gatedMode || gateActive);
    strb.cntLoad = wrEn && (wrAddr == ADDR_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN)         trigFlag <= 1'b0;
    else if (gateEdge) trigFlag <= 1'b1;
    else if (flagClr)  trigFlag <= 1'b0;
  end

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((gateSync != gateSyncD) && enReg && gatedMode && srcOk) |=> trigFlag);

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_STATUS && !wrData[0] && gateSync == gateSyncD) |=> !trigFlag);

  // R5
  no_run_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enReg) |-> !strb.run);
endmodule

// File: rtl/gtDatapath.sv
module gtDatapath
  import gtPkg::*;
#(
  parameter int PRE_W = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  gtStrobe_t        strb,
  input  logic [PRE_W-1:0] pscVal,
  input  logic [CNT_W-1:0] perVal,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cntValue
);
  logic [PRE_W-1:0] psCnt;
  logic             tick;

  assign tick = strb.run && (psCnt >= pscVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psCnt    <= '0;
      cntValue <= '0;
    end else if (strb.cntLoad) begin
      psCnt    <= '0;
      cntValue <= loadVal;
    end else if (strb.run) begin
      if (tick) begin
        psCnt    <= '0;
        cntValue <= (cntValue >= perVal) ? '0 : cntValue + 1'b1;
      end else begin
        psCnt <= psCnt + 1'b1;
      end
    end
  end

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.cntLoad) |=> $stable(cntValue));

  // R11
  load_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntLoad |=> (cntValue == $past(loadVal)));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strb.cntLoad && cntValue == perVal) |=> (cntValue == '0));
endmodule

// File: rtl/gatedTimer.sv
module gatedTimer
  import gtPkg::*;
#(
  parameter int PRE_W       = 16,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             gateIn,
  output logic [CNT_W-1:0] cntValue,
  output logic             trigFlag
);
  gtStrobe_t        strb;
  logic [PRE_W-1:0] pscVal;
  logic [CNT_W-1:0] perVal;

  gtControl #(.PRE_W(PRE_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .gateIn(gateIn), .strb(strb), .pscVal(pscVal), .perVal(perVal),
    .trigFlag(trigFlag)
  );

  gtDatapath #(.PRE_W(PRE_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .pscVal(pscVal), .perVal(perVal),
    .loadVal(wrData), .cntValue(cntValue)
  );
endmodule

// File: tb/tb_gatedTimer.sv
module tb_gatedTimer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        gateIn = 1'b0;
  logic [31:0] cntValue;
  logic        trigFlag;

  int nChecks = 0;
  int nFails = 0;
  bit summaryDone = 0;

  gatedTimer dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .gateIn(gateIn), .cntValue(cntValue), .trigFlag(trigFlag));

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    // R1 reset state
    check("R1 counter", cntValue, 0);
    check("R1 flag", {31'd0, trigFlag}, 0);
    waitN(4);
    check("R1 disabled", cntValue, 0);

    // R3 R4 sweep over prescaler and period, free-running mode (R2 addresses)
    for (int p = 0; p < 4; p++) begin
      for (int q = 0; q < 5; q++) begin
        writeReg(3'd0, 0);
        writeReg(3'd2, p);
        writeReg(3'd3, q);
        writeReg(3'd4, 0);
        writeReg(3'd0, 1);
        for (int k = 0; k < 13; k++) begin
          check("R3/R4 sweep", cntValue, (k / (p + 1)) % (q + 1));
          @(negedge clk);
        end
      end
    end

    // R5 hold while disabled
    writeReg(3'd0, 0);
    begin
      logic [31:0] held;
      held = cntValue;
      waitN(10);
      check("R5 hold", cntValue, held);
    end

    // R11 load priority while running, prescaler 0
    writeReg(3'd2, 0);
    writeReg(3'd3, 32'hFFFF_FFFF);
    writeReg(3'd0, 1);
    waitN(3);
    writeReg(3'd4, 1000);
    check("R11 load wins", cntValue, 1000);
    waitN(1);
    check("R11 after load", cntValue, 1001);
    // R11 prescaler phase restart
    writeReg(3'd2, 3);
    waitN(2);
    writeReg(3'd4, 50);
    for (int k = 0; k < 9; k++) begin
      check("R11 phase", cntValue, 50 + k / 4);
      @(negedge clk);
    end

    // R6 R8 R9 gated, active high
    writeReg(3'd0, 0);
    writeReg(3'd2, 0);
    writeReg(3'd1, 32'h55);
    writeReg(3'd4, 0);
    writeReg(3'd5, 0);
    writeReg(3'd0, 1);
    waitN(5);
    check("R6 closed", cntValue, 0);
    check("R9 no event", {31'd0, trigFlag}, 0);
    gateIn = 1'b1;
    waitN(2);
    check("R6 latency", cntValue, 0);
    check("R9 not yet", {31'd0, trigFlag}, 0);
    waitN(1);
    check("R6 first inc", cntValue, 1);
    check("R9 open event", {31'd0, trigFlag}, 1);
    waitN(5);
    check("R6 counting", cntValue, 6);
    writeReg(3'd5, 0);
    check("R10 cleared", {31'd0, trigFlag}, 0);
    check("R6 count at clear", cntValue, 7);
    gateIn = 1'b0;
    waitN(2);
    check("R8 close latency", cntValue, 9);
    check("R9 not yet close", {31'd0, trigFlag}, 0);
    waitN(1);
    check("R9 close event", {31'd0, trigFlag}, 1);
    waitN(10);
    check("R8 hold closed", cntValue, 9);
    check("R10 sticky", {31'd0, trigFlag}, 1);
    gateIn = 1'b1;
    waitN(3);
    check("R8 resume", cntValue, 10);

    // R6 active low
    writeReg(3'd0, 0);
    writeReg(3'd4, 0);
    writeReg(3'd0, 3);
    waitN(5);
    check("R6 low closed", cntValue, 0);
    gateIn = 1'b0;
    waitN(3);
    check("R6 low open", cntValue, 1);
    writeReg(3'd0, 2);
    check("R5 disable edge", cntValue, 2);
    writeReg(3'd5, 0);
    // R5 R9 gate changes while disabled
    gateIn = 1'b1;
    waitN(5);
    gateIn = 1'b0;
    waitN(5);
    check("R5 gated off", cntValue, 2);
    check("R9 no event off", {31'd0, trigFlag}, 0);

    // R7 other gate source
    writeReg(3'd1, 32'h05);
    writeReg(3'd0, 1);
    gateIn = 1'b1;
    waitN(10);
    check("R7 no count", cntValue, 2);
    check("R7 no event", {31'd0, trigFlag}, 0);

    finishRun();
  end
endmodule